// File: doc/BRIEF.md
# Signal Detect Conditioning and Status

This block takes the signal-detect pin of a fiber receiver and turns it into the clean, debounced level that a PCS needs before it can start word synchronization. The pin is first passed through an optional polarity inversion. It then goes through a two-flop synchronizer and a short stability check that always removes single-cycle excursions. After that comes a hold filter, which accepts a new level only once that level has persisted for a programmable number of cycles. When the filter is switched off, the hold filter's output is replaced by a constant 1.

A second status path reports an analog signal-detect level. The reported level comes either from the analog front end or from a software-programmed override bit. Both the filtered level and the analog level feed sticky change flags. Such a flag sets on any toggle of its level and clears when a status-read strobe is asserted. If the toggle and the read land in the same cycle, the toggle wins.

A separate link-lost latch is armed by a write strobe. Once armed, it captures any cycle in which the link-up indication is low. It keeps that indication until the next arm write. The read strobe does not clear it.

Top module: `sigdet_cond`

## Requirements
- R1: `st_pin_o` equals `sd_pin_i` as sampled at the previous rising clock edge, with no inversion or filtering.
- R2: `st_pol_o` equals `sd_pin_i XOR ctl_invert_i` as sampled at the previous rising edge. A 0 on `ctl_invert_i` passes the pin through unchanged and a 1 inverts it.
- R3: A polarity-adjusted level that lasts only one cycle never reaches the hold filter. A high level broken by one-cycle low gaps counts as continuously high, and isolated one-cycle high pulses count as low.
- R4: With `ctl_filt_en_i` = 1, a new polarity-adjusted level reaches `st_filt_o` only after it has been held for `HOLD_CYCLES` cycles (default 8). A level held for 8 cycles is accepted and a level held for 7 is not. With the default parameters, `st_filt_o` changes 13 rising edges after the pin changes.
- R5: When `ctl_filt_en_i` = 0, `st_filt_o` is 1 from the next rising edge onward, whatever the pin does.
- R6: `st_filt_chg_o` becomes 1 one rising edge after `st_filt_o` changes. It stays 1 until a rising edge at which `rd_strobe_i` = 1, and that edge clears it.
- R7: `st_ana_o` equals `ana_det_i` when `ctl_ana_src_i` = 1 and equals `ctl_ana_ovr_i` when `ctl_ana_src_i` = 0, both as sampled at the previous rising edge. The unselected input has no effect.
- R8: `st_ana_chg_o` becomes 1 one rising edge after `st_ana_o` changes and is cleared by `rd_strobe_i` under the same rules as R6.
- R9: When a change of a status level and `rd_strobe_i` meet at the same rising edge, the change flag ends that edge set to 1.
- R10: `st_link_lost_o` never sets before the first `arm_wr_i` pulse. A rising edge with `arm_wr_i` = 1 clears it and arms the latch. Once the latch is armed, any edge at which `link_up_i` = 0 and `arm_wr_i` = 0 sets it. It then holds until the next arm write, and `rd_strobe_i` does not affect it.
- R11: While `rst` is high at a rising edge, all status outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_pin_i | input | 1 | Raw signal-detect pin |
| ana_det_i | input | 1 | Analog front-end signal detect |
| link_up_i | input | 1 | Link-up indication from the PCS |
| ctl_invert_i | input | 1 | 1 inverts the pin polarity |
| ctl_filt_en_i | input | 1 | 1 enables the hold filter, 0 forces its output high |
| ctl_ana_src_i | input | 1 | 1 selects `ana_det_i`, 0 selects `ctl_ana_ovr_i` |
| ctl_ana_ovr_i | input | 1 | Software override value for the analog status |
| arm_wr_i | input | 1 | Strobe that clears and arms the link-lost latch |
| rd_strobe_i | input | 1 | Status-read strobe that clears the change flags |
| st_pin_o | output | 1 | Registered raw pin |
| st_pol_o | output | 1 | Registered polarity-adjusted pin |
| st_filt_o | output | 1 | Filtered signal detect |
| st_ana_o | output | 1 | Selected analog signal detect |
| st_filt_chg_o | output | 1 | Sticky change flag of `st_filt_o` |
| st_ana_chg_o | output | 1 | Sticky change flag of `st_ana_o` |
| st_link_lost_o | output | 1 | Latched link-lost flag |

## Verification
The filter path is driven with four pin patterns. A high level broken by one-cycle low gaps must be accepted, and isolated one-cycle high pulses must be dropped; together these separate the always-on stability check from the hold filter. Pulses of seven and eight cycles bracket the hold count exactly. The accepted eight-cycle pulse also pins down the 13-edge latency and the edge at which the change flag sets. A mux table covers every combination of pin, polarity and analog source, and shows that the unselected analog input is ignored. Directed steps then place a toggle and a read at the same edge, and exercise the link-lost latch before arming, after arming, and with the link held down during the arm write.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

  // control bits gathered from the configuration inputs
  typedef struct packed {
    logic invert;
    logic filt_en;
    logic ana_src;
    logic ana_ovr;
  } sd_ctl_t;

  // positions of the sticky change flags in the flag bank
  localparam int unsigned CHG_FILT = 0;
  localparam int unsigned CHG_ANA  = 1;
  localparam int unsigned NUM_CHG  = 2;

endpackage

// File: rtl/sd_deglitch.sv
// Synchronizer followed by a stability window: the output takes a new
// level only once every entry of the window holds it.
module sd_deglitch #(
  parameter int unsigned SYNC_STAGES   = 2,  // at least 2
  parameter int unsigned STABLE_CYCLES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned HIST_W = STABLE_CYCLES - 1;

  logic [SYNC_STAGES-1:0]   sync_q;
  logic [HIST_W-1:0]        hist_q;
  logic [STABLE_CYCLES-1:0] win;
  logic                     lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) begin
        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q[0] <= sync_q[SYNC_STAGES-1];
      for (int i = 1; i < int'(HIST_W); i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  assign win = {hist_q, sync_q[SYNC_STAGES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
    end else if (&win) begin
      lvl_q <= 1'b1;
    end else if (~|win) begin
      lvl_q <= 1'b0;
    end
  end

  assign q_o = lvl_q;

endmodule

// File: rtl/sd_hold_filter.sv
// Accepts a new input level only after it has persisted HOLD_CYCLES edges.
module sd_hold_filter #(
  parameter int unsigned HOLD_CYCLES = 8   // at least 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned CW       = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST_C = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST_C) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;

endmodule

// File: rtl/sd_sticky_bank.sv
// One sticky change flag per level; a toggle outranks the clear.
module sd_sticky_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    logic prev_q;
    logic flag_q;
    logic toggle;

    assign toggle = lvl_i[g] ^ prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= lvl_i[g];
        flag_q <= toggle | (flag_q & ~clr_i);
      end
    end

    assign flag_o[g] = flag_q;
  end

endmodule

// File: rtl/sd_link_latch.sv
// Armed by a write strobe; records any cycle with the link down afterwards.
module sd_link_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic link_up_i,
  output logic lost_o
);

  logic armed_q;
  logic lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      lost_q  <= 1'b0;
    end else if (armed_q && !link_up_i) begin
      lost_q  <= 1'b1;
    end
  end

  assign lost_o = lost_q;

endmodule

// File: rtl/sigdet_cond.sv
module sigdet_cond
  import sigdet_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 2,
  parameter int unsigned HOLD_CYCLES   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sd_pin_i,
  input  logic ana_det_i,
  input  logic link_up_i,
  input  logic ctl_invert_i,
  input  logic ctl_filt_en_i,
  input  logic ctl_ana_src_i,
  input  logic ctl_ana_ovr_i,
  input  logic arm_wr_i,
  input  logic rd_strobe_i,
  output logic st_pin_o,
  output logic st_pol_o,
  output logic st_filt_o,
  output logic st_ana_o,
  output logic st_filt_chg_o,
  output logic st_ana_chg_o,
  output logic st_link_lost_o
);

  sd_ctl_t            ctl;
  logic               pol_c;
  logic               clean_lvl;
  logic               held_lvl;
  logic               pin_q, pol_q, filt_q, ana_q;
  logic [NUM_CHG-1:0] chg_lvl;
  logic [NUM_CHG-1:0] chg_flag;

  assign ctl = '{invert:  ctl_invert_i,
                 filt_en: ctl_filt_en_i,
                 ana_src: ctl_ana_src_i,
                 ana_ovr: ctl_ana_ovr_i};

  assign pol_c = sd_pin_i ^ ctl.invert;

  sd_deglitch #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_CYCLES(STABLE_CYCLES)
  ) deglitch_i (
    .clk(clk),
    .rst(rst),
    .d_i(pol_c),
    .q_o(clean_lvl)
  );

  sd_hold_filter #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) hold_i (
    .clk(clk),
    .rst(rst),
    .d_i(clean_lvl),
    .q_o(held_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      pol_q  <= 1'b0;
      filt_q <= 1'b0;
      ana_q  <= 1'b0;
    end else begin
      pin_q  <= sd_pin_i;
      pol_q  <= pol_c;
      filt_q <= ctl.filt_en ? held_lvl : 1'b1;
      ana_q  <= ctl.ana_src ? ana_det_i : ctl.ana_ovr;
    end
  end

  assign chg_lvl[CHG_FILT] = filt_q;
  assign chg_lvl[CHG_ANA]  = ana_q;

  sd_sticky_bank #(
    .N(NUM_CHG)
  ) flags_i (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (chg_lvl),
    .clr_i (rd_strobe_i),
    .flag_o(chg_flag)
  );

  sd_link_latch link_i (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_wr_i),
    .link_up_i(link_up_i),
    .lost_o   (st_link_lost_o)
  );

  assign st_pin_o      = pin_q;
  assign st_pol_o      = pol_q;
  assign st_filt_o     = filt_q;
  assign st_ana_o      = ana_q;
  assign st_filt_chg_o = chg_flag[CHG_FILT];
  assign st_ana_chg_o  = chg_flag[CHG_ANA];

endmodule

// File: rtl/sigdet_cond_chk.sv
module sigdet_cond_chk (
  input logic clk,
  input logic rst,
  input logic sd_pin_i,
  input logic ana_det_i,
  input logic link_up_i,
  input logic ctl_invert_i,
  input logic ctl_filt_en_i,
  input logic ctl_ana_src_i,
  input logic ctl_ana_ovr_i,
  input logic arm_wr_i,
  input logic rd_strobe_i,
  input logic st_pin_o,
  input logic st_pol_o,
  input logic st_filt_o,
  input logic st_ana_o,
  input logic st_filt_chg_o,
  input logic st_ana_chg_o,
  input logic st_link_lost_o
);

  // high once the previous edge was already out of reset
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_raw_pin_r1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    st_pin_o == $past(sd_pin_i));

  p_polarity_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    st_pol_o == ($past(sd_pin_i) ^ $past(ctl_invert_i)));

  p_bypass_high_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(ctl_filt_en_i) |-> st_filt_o);

  p_filt_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_filt_chg_o && !rd_strobe_i) |=> st_filt_chg_o);

  p_filt_flag_clear_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (rd_strobe_i && st_filt_o == $past(st_filt_o)) |=> !st_filt_chg_o);

  p_ana_select_r7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    st_ana_o == ($past(ctl_ana_src_i) ? $past(ana_det_i) : $past(ctl_ana_ovr_i)));

  p_ana_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st_ana_chg_o && !rd_strobe_i) |=> st_ana_chg_o);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (st_filt_o != $past(st_filt_o)) |=> st_filt_chg_o);

  p_link_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st_link_lost_o && !arm_wr_i) |=> st_link_lost_o);

  p_link_clear_r10: assert property (@(posedge clk) disable iff (rst)
    arm_wr_i |=> !st_link_lost_o);

  p_link_set_r10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(arm_wr_i) && !arm_wr_i && !link_up_i) |=> st_link_lost_o);

endmodule

bind sigdet_cond sigdet_cond_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .sd_pin_i      (sd_pin_i),
  .ana_det_i     (ana_det_i),
  .link_up_i     (link_up_i),
  .ctl_invert_i  (ctl_invert_i),
  .ctl_filt_en_i (ctl_filt_en_i),
  .ctl_ana_src_i (ctl_ana_src_i),
  .ctl_ana_ovr_i (ctl_ana_ovr_i),
  .arm_wr_i      (arm_wr_i),
  .rd_strobe_i   (rd_strobe_i),
  .st_pin_o      (st_pin_o),
  .st_pol_o      (st_pol_o),
  .st_filt_o     (st_filt_o),
  .st_ana_o      (st_ana_o),
  .st_filt_chg_o (st_filt_chg_o),
  .st_ana_chg_o  (st_ana_chg_o),
  .st_link_lost_o(st_link_lost_o)
);

// File: tb/sigdet_cond_tb_top.sv
`timescale 1ns/1ps
module sigdet_cond_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_pin = 1'b0, ana_det = 1'b0, link_up = 1'b1;
  logic inv = 1'b0, filt_en = 1'b1, ana_src = 1'b0, ana_ovr = 1'b0;
  logic arm = 1'b0, rd = 1'b0;
  logic st_pin, st_pol, st_filt, st_ana, st_filt_chg, st_ana_chg, st_lost;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sigdet_cond dut_i (
    .clk(clk), .rst(rst),
    .sd_pin_i(sd_pin), .ana_det_i(ana_det), .link_up_i(link_up),
    .ctl_invert_i(inv), .ctl_filt_en_i(filt_en),
    .ctl_ana_src_i(ana_src), .ctl_ana_ovr_i(ana_ovr),
    .arm_wr_i(arm), .rd_strobe_i(rd),
    .st_pin_o(st_pin), .st_pol_o(st_pol), .st_filt_o(st_filt),
    .st_ana_o(st_ana), .st_filt_chg_o(st_filt_chg),
    .st_ana_chg_o(st_ana_chg), .st_link_lost_o(st_lost)
  );

  // {pin, invert, ana_src, ana_det, ana_ovr, exp_pin, exp_pol, exp_ana}
  localparam logic [7:0] VEC [8] = '{
    8'b00100_000, 8'b10110_111, 8'b11101_100, 8'b01001_011,
    8'b00010_000, 8'b11011_101, 8'b01110_011, 8'b10000_110
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_pulse();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R11 reset state
    chk("R11 pin", st_pin, 1'b0);       chk("R11 pol", st_pol, 1'b0);
    chk("R11 filt", st_filt, 1'b0);     chk("R11 ana", st_ana, 1'b0);
    chk("R11 fchg", st_filt_chg, 1'b0); chk("R11 achg", st_ana_chg, 1'b0);
    chk("R11 lost", st_lost, 1'b0);
    rst = 1'b0;

    // R1 R2 R7 mux table
    for (int i = 0; i < 8; i++) begin
      {sd_pin, inv, ana_src, ana_det, ana_ovr} = VEC[i][7:3];
      step(1);
      chk("R1 raw pin", st_pin, VEC[i][2]);
      chk("R2 polarity", st_pol, VEC[i][1]);
      chk("R7 analog select", st_ana, VEC[i][0]);
    end

    sd_pin = 0; inv = 0; ana_src = 0; ana_ovr = 0; ana_det = 0;
    step(30); read_pulse();
    chk("R6 cleared by read", st_filt_chg, 1'b0);
    chk("R8 cleared by read", st_ana_chg, 1'b0);

    // R3: high level with one-cycle low gaps is seen as steady high
    for (int k = 0; k < 6; k++) begin
      sd_pin = 1; step(3); sd_pin = 0; step(1);
    end
    sd_pin = 1;
    chk("R3 gaps rejected", st_filt, 1'b1);
    step(5);
    chk("R3 gaps rejected hold", st_filt, 1'b1);
    sd_pin = 0; step(30); read_pulse();
    chk("R3 back low", st_filt, 1'b0);

    // R3: isolated one-cycle high pulses are dropped
    for (int k = 0; k < 5; k++) begin
      sd_pin = 1; step(1); sd_pin = 0; step(3);
    end
    step(20);
    chk("R3 pulses rejected", st_filt, 1'b0);
    chk("R3 no change flag", st_filt_chg, 1'b0);

    // R4: 7-cycle pulse rejected
    sd_pin = 1; step(7); sd_pin = 0; step(30);
    chk("R4 seven cycles rejected", st_filt, 1'b0);
    chk("R4 seven no flag", st_filt_chg, 1'b0);

    // R4: 8-cycle pulse accepted, 13 edges after the pin change
    sd_pin = 1; step(8); sd_pin = 0; step(4);
    chk("R4 before latency", st_filt, 1'b0);
    chk("R6 flag not yet", st_filt_chg, 1'b0);
    step(1);
    chk("R4 at latency", st_filt, 1'b1);
    chk("R6 flag one edge later", st_filt_chg, 1'b0);
    step(1);
    chk("R6 flag set", st_filt_chg, 1'b1);
    step(20);
    chk("R6 flag held", st_filt_chg, 1'b1);
    chk("R4 returns low", st_filt, 1'b0);
    read_pulse();
    chk("R6 read clears", st_filt_chg, 1'b0);

    // R5 bypass, R9 set wins
    filt_en = 0; step(1);
    chk("R5 bypass forces high", st_filt, 1'b1);
    step(5);
    chk("R5 bypass holds high", st_filt, 1'b1);
    filt_en = 1; step(1);
    rd = 1; step(1); rd = 0;
    chk("R9 set wins over read", st_filt_chg, 1'b1);
    chk("R5 filter restored", st_filt, 1'b0);
    read_pulse();
    chk("R6 read clears after set-wins", st_filt_chg, 1'b0);

    // R7 R8 analog path
    ana_ovr = 1; step(1);
    chk("R7 override selected", st_ana, 1'b1);
    chk("R8 flag not yet", st_ana_chg, 1'b0);
    step(1);
    chk("R8 flag set", st_ana_chg, 1'b1);
    step(10);
    chk("R8 flag held", st_ana_chg, 1'b1);
    read_pulse();
    chk("R8 read clears", st_ana_chg, 1'b0);
    ana_src = 1; ana_det = 0; step(2);
    chk("R7 analog input selected", st_ana, 1'b0);
    chk("R8 toggle via source", st_ana_chg, 1'b1);
    read_pulse();
    ana_ovr = 0; step(3);
    chk("R7 override ignored", st_ana, 1'b0);
    ana_ovr = 1; step(3);
    chk("R7 override ignored again", st_ana, 1'b0);
    chk("R8 no flag from ignored input", st_ana_chg, 1'b0);

    // R10 link-lost latch
    link_up = 0; step(3);
    chk("R10 unarmed no set", st_lost, 1'b0);
    link_up = 1; arm = 1; step(1); arm = 0;
    chk("R10 armed clear", st_lost, 1'b0);
    step(2);
    chk("R10 link up no set", st_lost, 1'b0);
    link_up = 0; step(1);
    chk("R10 sets on link down", st_lost, 1'b1);
    link_up = 1; step(5); read_pulse();
    chk("R10 read does not clear", st_lost, 1'b1);
    link_up = 0; arm = 1; step(1); arm = 0;
    chk("R10 arm clears", st_lost, 1'b0);
    step(1);
    chk("R10 resets while down", st_lost, 1'b1);
    link_up = 1; arm = 1; step(1); arm = 0; step(5);
    chk("R10 stays clear", st_lost, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule